// File: doc/BRIEF.md
# MII Transmit Symbol Encoder

This block sits between a MAC's nibble-wide transmit interface and a physical medium layer that expects 5-bit code-groups. Every cycle of the 25 MHz transmit clock it registers the MAC's nibble, enable and error lines. A framing sequencer then turns them into one code-group. The code-group passes through an optional stream-cipher scrambler and is registered onto the symbol output.

Frames are bounded by delimiter pairs. The first two nibble slots of a frame are overwritten by a start pair, and an end pair follows the last nibble. Between frames the line carries idle code-groups. When the MAC marks a nibble as bad, a halt code-group is sent in its place. A static bypass input skips the scrambler, for media that need no spectral whitening, such as optical links.

Top module: `mii_tx_symbol_path`

## Requirements
- R1: While `rst_n` is low, `sym_out` is the idle code-group 5'b11111, and the scrambler register holds the non-zero `SEED` parameter (default 11'h5A5).
- R2: A nibble presented before clock edge k appears on `sym_out` after edge k+1: there are exactly two register stages.
- R3: In a data slot the nibble maps to these 5-bit code-groups (bit 4 written leftmost): 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. `tx_nib[0]` is the least significant bit.
- R4: The first slot in which registered enable is seen high, starting from idle, emits J (11000). The next slot always emits K (10001). The nibbles of those two slots are dropped.
- R5: A data slot whose registered enable and error are both high emits H (00100) in place of the encoded nibble. An error raised while enable is low, or during the J and K slots, has no effect on the output.
- R6: The first data-phase slot with enable low emits T (01101), and the slot after it emits R (00111). The block then returns to idle.
- R7: Idle slots with enable low emit I (11111).
- R8: With `scram_off` low, every output symbol, idle included, is XORed with 5 key bits from an 11-bit LFSR s[n] = s[n-11] xor s[n-9]. The LFSR runs 5 steps per clock, including during idle. Key bit i is the i-th newly generated bit and is XORed into symbol bit i. The register's bit 10 is the oldest bit. `SEED` bit 10 down to bit 0 supplies s[0] up to s[10].
- R9: With `scram_off` high, the unscrambled code-group is output, while the LFSR keeps advancing.
- R10: If enable is already low in the K slot, T follows K directly. If enable is high during the R slot, that nibble is dropped and J follows R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | MAC transmit enable |
| tx_err | input | 1 | MAC transmit error flag |
| tx_nib | input | 4 | MAC transmit nibble, bit 0 least significant |
| scram_off | input | 1 | Static scrambler bypass, high means unscrambled |
| sym_out | output | 5 | Registered code-group to the medium layer |

## Verification
An error flag can land in the same slot as a frame delimiter. The bench raises `tx_err` on the first nibble of a frame, where J overwrites it, and on the nibble right after enable drops, where T is due. The reference model predicts the delimiter in both slots and the halt code only inside the data phase.

Frame end and frame start can also collide. The bench reasserts enable during the R slot, and the model expects that nibble to be lost and J to follow R. Every comparison is made on each clock in both scrambled and bypassed operation.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  localparam int NIB_W  = 4;
  localparam int SYM_W  = 5;
  localparam int LFSR_W = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_SSD2, ST_DATA, ST_ESD2} frm_st_t;

  localparam logic [SYM_W-1:0] CG_I = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R = 5'b00111;
  localparam logic [SYM_W-1:0] CG_H = 5'b00100;

  function automatic logic [SYM_W-1:0] enc_4b5b(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  // One LFSR step: feedback from the oldest bit and the bit two younger.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-3]};
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < SYM_W; i++) t = lfsr_step(t);
    return t;
  endfunction

  // Key bit i is the i-th new bit produced while advancing.
  function automatic logic [SYM_W-1:0] lfsr_key(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    logic [SYM_W-1:0]  k;
    t = s;
    for (int i = 0; i < SYM_W; i++) begin
      t    = lfsr_step(t);
      k[i] = t[0];
    end
    return k;
  endfunction
endpackage

// File: rtl/mii_tx_nibble_reg.sv
module mii_tx_nibble_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_d,
  input  logic         err_d,
  input  logic [W-1:0] nib_d,
  output logic         en_q,
  output logic         err_q,
  output logic [W-1:0] nib_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
      nib_q <= '0;
    end else begin
      en_q  <= en_d;
      err_q <= err_d;
      nib_q <= nib_d;
    end
  end
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mii_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic             err_q,
  input  logic [NIB_W-1:0] nib_q,
  output logic [SYM_W-1:0] code,
  output logic             frame_start,
  output logic             frame_end,
  output logic             err_slot,
  output logic             in_idle
);
  frm_st_t st_q, st_nxt;

  always_comb begin
    code        = CG_I;
    st_nxt      = st_q;
    frame_start = 1'b0;
    frame_end   = 1'b0;
    err_slot    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en_q) begin
          code        = CG_J;
          st_nxt      = ST_SSD2;
          frame_start = 1'b1;
        end
      end
      ST_SSD2: begin
        code   = CG_K;
        st_nxt = ST_DATA;
      end
      ST_DATA: begin
        if (en_q) begin
          if (err_q) begin
            code     = CG_H;
            err_slot = 1'b1;
          end else begin
            code = enc_4b5b(nib_q);
          end
        end else begin
          code      = CG_T;
          st_nxt    = ST_ESD2;
          frame_end = 1'b1;
        end
      end
      default: begin
        code   = CG_R;
        st_nxt = ST_IDLE;
      end
    endcase
  end

  assign in_idle = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nxt;
  end
endmodule

// File: rtl/mii_tx_scrambler.sv
module mii_tx_scrambler
  import mii_tx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 11'h5A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic [SYM_W-1:0]  code_in,
  output logic [SYM_W-1:0]  sym_d,
  output logic [LFSR_W-1:0] lfsr_q
);
  logic [SYM_W-1:0] key;

  assign key   = lfsr_key(lfsr_q);
  assign sym_d = bypass ? code_in : (code_in ^ key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_adv(lfsr_q);
  end
endmodule

// File: rtl/mii_tx_symbol_path.sv
module mii_tx_symbol_path
  import mii_tx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 11'h5A5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_err,
  input  logic [NIB_W-1:0] tx_nib,
  input  logic             scram_off,
  output logic [SYM_W-1:0] sym_out
);
  logic              en_q, err_q;
  logic [NIB_W-1:0]  nib_q;
  logic [SYM_W-1:0]  slot_code, sym_d;
  logic              frame_start, frame_end, err_slot, in_idle;
  logic [LFSR_W-1:0] lfsr_q;

  mii_tx_nibble_reg #(.W(NIB_W)) u_nib (
    .clk(clk), .rst_n(rst_n),
    .en_d(tx_en), .err_d(tx_err), .nib_d(tx_nib),
    .en_q(en_q), .err_q(err_q), .nib_q(nib_q)
  );

  mii_tx_framer u_frm (
    .clk(clk), .rst_n(rst_n),
    .en_q(en_q), .err_q(err_q), .nib_q(nib_q),
    .code(slot_code), .frame_start(frame_start), .frame_end(frame_end),
    .err_slot(err_slot), .in_idle(in_idle)
  );

  mii_tx_scrambler #(.SEED(SEED)) u_scr (
    .clk(clk), .rst_n(rst_n), .bypass(scram_off),
    .code_in(slot_code), .sym_d(sym_d), .lfsr_q(lfsr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sym_out <= CG_I;
    else        sym_out <= sym_d;
  end
endmodule

// File: rtl/mii_tx_symbol_path_chk.sv
module mii_tx_symbol_path_chk
  import mii_tx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scram_off,
  input logic              en_q,
  input logic [SYM_W-1:0]  sym_out,
  input logic [SYM_W-1:0]  slot_code,
  input logic              frame_start,
  input logic              frame_end,
  input logic              err_slot,
  input logic              in_idle,
  input logic [LFSR_W-1:0] lfsr_q
);
  a_r4_k_after_j: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> slot_code == CG_K);

  a_r6_r_after_t: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> slot_code == CG_R);

  a_r5_halt_out: assert property (@(posedge clk) disable iff (!rst_n)
    (err_slot && scram_off) |=> sym_out == CG_H);

  a_r7_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !en_q && scram_off) |=> sym_out == CG_I);

  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    scram_off |=> sym_out == $past(slot_code));

  a_r8_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  a_r10_one_delim: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && frame_end));
endmodule

bind mii_tx_symbol_path mii_tx_symbol_path_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scram_off(scram_off), .en_q(en_q),
  .sym_out(sym_out), .slot_code(slot_code), .frame_start(frame_start),
  .frame_end(frame_end), .err_slot(err_slot), .in_idle(in_idle),
  .lfsr_q(lfsr_q)
);

// File: tb/mii_tx_symbol_path_tb_top.sv
module mii_tx_symbol_path_tb_top;
  localparam logic [10:0] SEED = 11'h5A5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_err = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic       scram_off = 1'b1;
  logic [4:0] sym_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mii_tx_symbol_path #(.SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_err(tx_err),
    .tx_nib(tx_nib), .scram_off(scram_off), .sym_out(sym_out)
  );

  // Reference model: slot phase counter plus a bit-history queue.
  bit [4:0] cg_tab [16];
  bit       hist [$];
  int       phase;
  bit       p_en, p_err;
  bit [3:0] p_nib;
  bit [4:0] exp_sym;
  string    exp_tag;
  bit       last_was_k;

  function automatic void model_reset();
    hist.delete();
    for (int i = 10; i >= 0; i--) hist.push_back(SEED[i]);
    phase = 0; p_en = 0; p_err = 0; p_nib = 0;
    exp_sym = 5'b11111; exp_tag = "R1"; last_was_k = 0;
  endfunction

  function automatic void model_edge();
    bit [4:0] code, key;
    string tag;
    bit was_k;
    was_k = last_was_k;
    last_was_k = 0;
    case (phase)
      0: if (p_en) begin code = 5'b11000; tag = "R4"; phase = 1; end
         else begin code = 5'b11111; tag = p_err ? "R5" : "R7"; end
      1: begin code = 5'b10001; tag = p_err ? "R5" : "R4"; phase = 2; last_was_k = 1; end
      2: if (p_en) begin
           if (p_err) begin code = 5'b00100; tag = "R5"; end
           else begin code = cg_tab[p_nib]; tag = "R3"; end
         end else begin
           code = 5'b01101; tag = was_k ? "R10" : "R6"; phase = 3;
         end
      default: begin code = 5'b00111; tag = p_en ? "R10" : "R6"; phase = 0; end
    endcase
    for (int i = 0; i < 5; i++) begin
      bit nb;
      nb = hist[0] ^ hist[2];
      hist.push_back(nb);
      void'(hist.pop_front());
      key[i] = nb;
    end
    if (scram_off) begin exp_sym = code; exp_tag = {tag, " R9"}; end
    else begin exp_sym = code ^ key; exp_tag = {tag, " R8"}; end
    p_en = tx_en; p_err = tx_err; p_nib = tx_nib;
  endfunction

  initial begin
    cg_tab = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
               5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
    model_reset();
  end

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_edge();
  end

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sym_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, at the falling edge.
  bit run_cmp = 0;
  always @(negedge clk) if (run_cmp) check(exp_tag, sym_out, exp_sym);

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_en = 0; tx_err = 0;
    end
  endtask

  task automatic frame(input int len, input bit [3:0] first, input int err_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      tx_en = 1; tx_nib = first + 4'(i); tx_err = (i == err_at);
    end
    @(negedge clk); tx_en = 0; tx_err = 0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", sym_out, 5'b11111);
    check("R1", dut_i.sym_out, 5'b11111);
    rst_n = 1;
    run_cmp = 1;
    idle(4);

    // R2: latency, checked directly. n2 driven before edge E3, visible after E4.
    run_cmp = 0;
    @(negedge clk); tx_en = 1; tx_nib = 4'h1;
    @(negedge clk); tx_nib = 4'h2;
    @(negedge clk); tx_nib = 4'h9;
    @(negedge clk); check("R2", sym_out, 5'b10001);
    tx_nib = 4'h3;
    @(negedge clk); check("R2", sym_out, 5'b10011);
    tx_en = 0;
    run_cmp = 1;
    idle(6);

    // R3/R9: all sixteen nibbles in bypass mode
    frame(20, 4'hE, -1);
    idle(3);
    // R5: error in data, in the J slot and right after enable drops
    frame(8, 4'h3, 4);
    frame(6, 4'h0, 0);
    @(negedge clk); tx_en = 1; tx_nib = 4'h7;
    repeat (3) @(negedge clk);
    tx_en = 0; tx_err = 1;
    @(negedge clk); tx_err = 0;
    idle(3);
    // R5: error without enable is ignored
    @(negedge clk); tx_err = 1;
    @(negedge clk); tx_err = 1;
    idle(3);
    // R10: single-nibble frame, then restart during the R slot
    frame(1, 4'h5, -1);
    idle(4);
    frame(4, 4'hA, -1);
    @(negedge clk); tx_en = 1;
    frame(5, 4'h2, -1);
    idle(4);

    // R8: scrambled operation, including idle
    @(negedge clk); scram_off = 0;
    idle(5);
    frame(18, 4'h0, 7);
    idle(4);
    frame(1, 4'hF, -1);
    idle(2);
    frame(3, 4'h6, -1);
    @(negedge clk); tx_en = 1;
    frame(6, 4'hB, 2);
    idle(6);
    @(negedge clk); scram_off = 1;
    idle(4);

    run_cmp = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule